// File: doc/BRIEF.md
# C-slow Interleaved Accumulator

This block is an accumulator whose single feedback register has been replaced by a ring of `NUM_CTX` registers. That change lets one datapath serve `NUM_CTX` independent streams, one after another. Each clock the block accepts one input word, and that word belongs to the stream named on `in_stream`. The stream number comes from a free-running counter that counts modulo `NUM_CTX`, so stream k is offered its next slot exactly `NUM_CTX` cycles after its previous one. Because the state a stream needs returns to the update logic exactly when that stream's next input arrives, no stream can see or disturb the state of another. Each stream behaves as a plain single-stream accumulator clocked at 1/`NUM_CTX` of the system clock.

Each stream has its own enable and its own clear. Both travel with the data word in the slot that belongs to the stream. They are applied as multiplexing in the datapath: clear selects zero, and a deasserted enable selects the old value. No flip-flop reset or enable is used for them, because that kind of control would act on every stream at once. The input word and its controls pass through an input register. The updated state is registered at the output together with the stream number it belongs to, so each result comes out tagged with its stream two cycles after it was presented.

A two-state phase machine qualifies the pipeline. `PH_IDLE` holds while the global reset is asserted. The transition `START` moves to `PH_RUN` at the first clock with reset released, and the machine stays in `PH_RUN` until reset is asserted again. The per-slot operation is decoded into three named cases: `OP_HOLD`, `OP_ADD` and `OP_CLEAR`.

Top module: `cslow_accum`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), every clock leaves `out_valid`=0, `out_data`=0 and `in_stream`=0, and all stream states become 0.
- R2: After reset, `in_stream` starts at 0 and advances by one each clock. After `NUM_CTX`-1 it returns to 0.
- R3: An input presented in the cycle where `in_stream`=k appears as a result two clocks later, with `out_stream`=k and `out_valid`=1. `out_valid` is 1 only for inputs that were presented while reset was released.
- R4: With `in_clr`=0 and `in_en`=1, the result of stream k is its previous state plus `in_data`, modulo 2^`DATA_W`, and this becomes the new state of stream k.
- R5: With `in_clr`=0 and `in_en`=0, the result of stream k equals its previous state, and `in_data` has no effect.
- R6: With `in_clr`=1, the result and new state of stream k are 0, whatever `in_en` and `in_data` are (clear takes priority over enable).
- R7: The clear, enable and data of stream k change no other stream's state.
- R8: For every stream, the sequence of results equals that of an ordinary accumulator fed only that stream's inputs, with overflow wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Global synchronous reset, active low |
| in_data | input | DATA_W | Operand for the stream currently accepting input |
| in_en | input | 1 | Enable for the accepting stream (0 holds its state) |
| in_clr | input | 1 | Clear for the accepting stream (zeroes its state) |
| in_stream | output | SID_W | Number of the stream that accepts input this cycle |
| out_valid | output | 1 | Result on `out_data` is valid |
| out_data | output | DATA_W | Updated state of the tagged stream |
| out_stream | output | SID_W | Stream that `out_data` belongs to |

## Verification
The clear and the enable of one stream can fall on the same slot. Clears of one stream can also fall on the slots just before and just after another stream's accumulating slots. The bench provokes both cases with directed patterns and then with a long random run, where each slot draws its clear and enable independently. Every tagged result is compared with a per-stream reference accumulator: a zero where clear and enable coincide, and unchanged sums on the neighbouring streams across each clear. An overflow pattern checks the wrap.

// File: rtl/cslow_pkg.sv
package cslow_pkg;

    // Operation applied to the state slot passing the update logic
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_ADD   = 2'd1,
        OP_CLEAR = 2'd2
    } ctx_op_e;

    // Pipeline qualification phase
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } pipe_phase_e;

    // Clear has priority over enable
    function automatic ctx_op_e decode_op(input logic clr, input logic en);
        ctx_op_e op;
        if (clr)
            op = OP_CLEAR;
        else if (en)
            op = OP_ADD;
        else
            op = OP_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/cslow_stream_ctr.sv
module cslow_stream_ctr #(
    parameter int NUM_CTX = 4,
    parameter int SID_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [SID_W-1:0] sid
);
    localparam logic [SID_W-1:0] LAST_SID = SID_W'(NUM_CTX - 1);

    logic [SID_W-1:0] sid_q;
    logic [SID_W-1:0] sid_d;

    always_comb begin
        if (sid_q == LAST_SID)
            sid_d = '0;
        else
            sid_d = sid_q + SID_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            sid_q <= '0;
        else
            sid_q <= sid_d;
    end

    assign sid = sid_q;
endmodule

// File: rtl/cslow_in_stage.sv
module cslow_in_stage
    import cslow_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SID_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_i,
    input  logic              en_i,
    input  logic              clr_i,
    input  logic [SID_W-1:0]  sid_i,
    output logic [DATA_W-1:0] data_o,
    output ctx_op_e           op_o,
    output logic [SID_W-1:0]  sid_o,
    output logic              valid_o
);
    pipe_phase_e phase_q;
    pipe_phase_e phase_d;

    // Next-state: START transition from PH_IDLE to PH_RUN
    always_comb begin
        unique case (phase_q)
            PH_IDLE: phase_d = PH_RUN;
            PH_RUN:  phase_d = PH_RUN;
            default: phase_d = PH_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= PH_IDLE;
        else
            phase_q <= phase_d;
    end

    // Captured slot contents
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            op_o   <= OP_HOLD;
            sid_o  <= '0;
        end else begin
            data_o <= data_i;
            op_o   <= decode_op(clr_i, en_i);
            sid_o  <= sid_i;
        end
    end

    // Output process of the phase machine
    always_comb begin
        unique case (phase_q)
            PH_RUN:  valid_o = 1'b1;
            default: valid_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/cslow_ctx_ring.sv
module cslow_ctx_ring #(
    parameter int NUM_CTX = 4,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] push_i,
    output logic [DATA_W-1:0] head_o
);
    logic [DATA_W-1:0] slot_q [NUM_CTX];

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_slot
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slot_q[i] <= '0;
                else
                    slot_q[i] <= push_i;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slot_q[i] <= '0;
                else
                    slot_q[i] <= slot_q[i-1];
            end
        end
    end

    assign head_o = slot_q[NUM_CTX-1];
endmodule

// File: rtl/cslow_ctx_update.sv
module cslow_ctx_update
    import cslow_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  ctx_op_e           op_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] state_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] state_o
);
    always_comb begin
        if (!valid_i) begin
            state_o = state_i;
        end else begin
            unique case (op_i)
                OP_CLEAR: state_o = '0;
                OP_ADD:   state_o = state_i + data_i;
                OP_HOLD:  state_o = state_i;
                default:  state_o = state_i;
            endcase
        end
    end
endmodule

// File: rtl/cslow_accum.sv
module cslow_accum
    import cslow_pkg::*;
#(
    parameter int NUM_CTX = 4,
    parameter int DATA_W  = 8,
    localparam int SID_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_en,
    input  logic              in_clr,
    output logic [SID_W-1:0]  in_stream,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [SID_W-1:0]  out_stream
);
    logic [SID_W-1:0]  cur_sid;
    logic [DATA_W-1:0] s1_data;
    ctx_op_e           s1_op;
    logic [SID_W-1:0]  s1_sid;
    logic              s1_valid;
    logic [DATA_W-1:0] ring_head;
    logic [DATA_W-1:0] upd_state;

    cslow_stream_ctr #(.NUM_CTX(NUM_CTX), .SID_W(SID_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .sid   (cur_sid)
    );

    cslow_in_stage #(.DATA_W(DATA_W), .SID_W(SID_W)) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_i  (in_data),
        .en_i    (in_en),
        .clr_i   (in_clr),
        .sid_i   (cur_sid),
        .data_o  (s1_data),
        .op_o    (s1_op),
        .sid_o   (s1_sid),
        .valid_o (s1_valid)
    );

    cslow_ctx_ring #(.NUM_CTX(NUM_CTX), .DATA_W(DATA_W)) u_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (upd_state),
        .head_o (ring_head)
    );

    cslow_ctx_update #(.DATA_W(DATA_W)) u_upd (
        .op_i    (s1_op),
        .valid_i (s1_valid),
        .state_i (ring_head),
        .data_i  (s1_data),
        .state_o (upd_state)
    );

    // Registered, stream-tagged result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_stream <= '0;
        end else begin
            out_valid  <= s1_valid;
            out_data   <= upd_state;
            out_stream <= s1_sid;
        end
    end

    assign in_stream = cur_sid;
endmodule

// File: rtl/cslow_accum_checker.sv
module cslow_accum_checker #(
    parameter int NUM_CTX = 4,
    parameter int DATA_W  = 8,
    parameter int SID_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_clr,
    input logic [SID_W-1:0]  in_stream,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic [SID_W-1:0]  out_stream
);
    localparam logic [SID_W-1:0] LAST_SID = SID_W'(NUM_CTX - 1);

    assert_reset_outputs_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0 && in_stream == '0));

    assert_stream_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stream != LAST_SID) |=> (in_stream == $past(in_stream) + SID_W'(1)));

    assert_stream_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stream == LAST_SID) |=> (in_stream == '0));

    assert_valid_after_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(rst_n));

    assert_out_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_stream == $past(in_stream, 2)));

    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_clr, 2)) |-> (out_data == '0));
endmodule

bind cslow_accum cslow_accum_checker #(
    .NUM_CTX (NUM_CTX),
    .DATA_W  (DATA_W),
    .SID_W   (SID_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_clr     (in_clr),
    .in_stream  (in_stream),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_stream (out_stream)
);

// File: tb/cslow_accum_bench.sv
module cslow_accum_bench;
    localparam int NUM_CTX = 4;
    localparam int DATA_W  = 8;
    localparam int SID_W   = 2;

    typedef struct {
        int    sid;
        int    val;
        string req;
    } exp_item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_en = 1'b0;
    logic              in_clr = 1'b0;
    logic [SID_W-1:0]  in_stream;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;
    logic [SID_W-1:0]  out_stream;

    int        n_checks = 0;
    int        n_fail   = 0;
    int        model [NUM_CTX];
    int        exp_sid  = 0;
    bit        done     = 1'b0;
    exp_item_t scb [$];

    always #10 clk = ~clk;

    cslow_accum #(.NUM_CTX(NUM_CTX), .DATA_W(DATA_W)) u_cslow_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_data    (in_data),
        .in_en      (in_en),
        .in_clr     (in_clr),
        .in_stream  (in_stream),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_stream (out_stream)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: called at a falling edge; presents one slot and pushes the expectation
    task automatic drive(input int data, input bit en, input bit clr);
        exp_item_t it;
        string     req;
        check(in_stream == SID_W'(exp_sid), "R2", int'(in_stream), exp_sid);
        if (clr) begin
            model[exp_sid] = 0;
            req = "R6";
        end else if (en) begin
            model[exp_sid] = (model[exp_sid] + data) % (1 << DATA_W);
            req = "R4";
        end else begin
            req = "R5";
        end
        it.sid = exp_sid;
        it.val = model[exp_sid];
        it.req = req;
        scb.push_back(it);
        in_data = DATA_W'(data);
        in_en   = en;
        in_clr  = clr;
        exp_sid = (exp_sid + 1) % NUM_CTX;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        in_en  = 1'b0;
        in_clr = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);
        check(out_data == '0, "R1", int'(out_data), 0);
        check(in_stream == '0, "R1", int'(in_stream), 0);
        scb.delete();
        for (int i = 0; i < NUM_CTX; i++) model[i] = 0;
        exp_sid = 0;
        rst_n = 1'b1;
    endtask

    // Monitor: pops and compares every tagged result
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (scb.size() == 0) begin
                check(1'b0, "R3", int'(out_stream), -1);
            end else begin
                exp_item_t it;
                it = scb.pop_front();
                check(int'(out_stream) == it.sid, "R3", int'(out_stream), it.sid);
                check(int'(out_data) == it.val, it.req, int'(out_data), it.val);
                check(int'(out_data) == it.val, "R8", int'(out_data), it.val);
            end
        end
    end

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R4: each stream accumulates its own values
        for (int r = 0; r < 3; r++)
            for (int s = 0; s < NUM_CTX; s++) drive(s * 10 + r + 1, 1'b1, 1'b0);
        // R5: data ignored while enable is low
        for (int s = 0; s < NUM_CTX; s++) drive(99, 1'b0, 1'b0);
        // R6 and R7: clear stream 1 with enable high, neighbours keep adding
        drive(1, 1'b1, 1'b0);
        drive(77, 1'b1, 1'b1);
        drive(1, 1'b1, 1'b0);
        drive(1, 1'b1, 1'b0);
        for (int s = 0; s < NUM_CTX; s++) drive(3, 1'b1, 1'b0);
        // R4: wrap modulo 2^DATA_W
        for (int r = 0; r < 3; r++)
            for (int s = 0; s < NUM_CTX; s++) drive(200, 1'b1, 1'b0);
        // R1: reset mid-run, then restart from zero
        do_reset();
        for (int s = 0; s < NUM_CTX; s++) drive(5, 1'b1, 1'b0);
        // R7 and R8: random per-stream enables and clears
        for (int k = 0; k < 600; k++) begin
            int d;
            bit e;
            bit c;
            d = int'($urandom_range(255));
            e = ($urandom_range(3) != 0);
            c = ($urandom_range(7) == 0);
            drive(d, e, c);
        end
        @(negedge clk);
        @(posedge clk);
        done = 1'b1;
        check(scb.size() == 0, "R8", scb.size(), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule